// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block holds the page selector that picks which bank of peripheral registers the CPU currently sees. When an interrupt is taken, the active page is saved one level down and the page that belongs to the interrupting peripheral becomes active in the same cycle. A handler can therefore touch its own peripheral's registers at once, without spending instructions on page switching. On interrupt return the saved page comes back.

The stack has three levels, so two nested interrupts (a high-priority one preempting a low-priority handler) can be saved. Software may overwrite any level at any time, the top level included, so the structure is not a pure LIFO. A global enable input turns the automatic save and restore on or off. The interrupt controller supplies the entry and return strobes and the peripheral's page number.

Top module: `page_stack`

## Requirements
- R1: After reset all three levels read 0x00 and `active_page` is 0x00.
- R2: `active_page` always equals the top level. A software write to the top level is visible on `active_page` from the clock edge that captures it.
- R3: With `stk_en`=1, a cycle with `irq_enter`=1 loads `irq_page` into the top level, moves the old top into the middle level and the old middle into the bottom level. The old bottom value is lost.
- R4: With `stk_en`=1, a cycle with `irq_return`=1 and `irq_enter`=0 moves the middle level to the top and the bottom level to the middle. The bottom level keeps its value.
- R5: With `stk_en`=0, `irq_enter` and `irq_return` change no level.
- R6: `sw_wr_en` bit 0 writes `sw_wdata` into the top level, bit 1 into the middle level and bit 2 into the bottom level. Several bits may be set in one cycle.
- R7: When an enabled entry or return happens in the same cycle as a software write, the interrupt event decides every level and the write is dropped. With `stk_en`=0, software writes take effect even while strobes are present.
- R8: If `irq_enter` and `irq_return` are both 1 with `stk_en`=1, the cycle behaves as an entry only.
- R9: `sw_rdata` shows, combinationally, the top level for `sw_rd_sel`=0, the middle for 1, the bottom for 2, and 0x00 for 3.
- R10: Two nested entries followed by two returns restore the page that was active before the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stk_en | input | 1 | Enables automatic save/restore (software holds it at 1 after reset) |
| irq_enter | input | 1 | One-cycle strobe: interrupt taken |
| irq_page | input | 8 | Page number of the interrupting peripheral |
| irq_return | input | 1 | One-cycle strobe: return from interrupt |
| sw_wr_en | input | 3 | Per-level software write enables (bit 0 top, bit 2 bottom) |
| sw_wdata | input | 8 | Software write data |
| sw_rd_sel | input | 2 | Software read level select |
| sw_rdata | output | 8 | Software read data |
| active_page | output | 8 | Page used by the register decoder |

## Verification
The hardest state to reach is the full three-level stack carrying distinct values after a handler has changed its own page, because only then can a wrong shift direction, a lost bottom value or a skipped software write be told apart. The stimulus first fills the middle and bottom levels by direct software writes, takes an entry, rewrites the top inside the handler, takes a nested entry and then unwinds with two returns. Collisions between software writes and strobes, and the enter-with-return case, are driven on purpose with data that differs from every value the stack holds.

// File: rtl/pgstk_pkg.sv
// Package: shared types for the page stack.
// Assumes: one operation per cycle is chosen by the control decoder.
package pgstk_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/pgstk_ctrl.sv
// Module: pgstk_ctrl
// Decodes the interrupt strobes and the enable bit into one stack operation.
// Assumes: entry outranks return when both strobes are set.
module pgstk_ctrl
    import pgstk_pkg::*;
(
    input  logic    stk_en,
    input  logic    irq_enter,
    input  logic    irq_return,
    output stk_op_e op
);
    // Pick the operation for this cycle.
    always_comb begin
        op = OP_IDLE;
        if (stk_en) begin
            if (irq_enter)       op = OP_PUSH;
            else if (irq_return) op = OP_POP;
        end
    end
endmodule

// File: rtl/pgstk_entry.sv
// Module: pgstk_entry
// One stack level. Push loads from the level above, pop from the level below;
// otherwise a software write may load it.
// Assumes: the parent ties "above" of the top level to the incoming page and
// "below" of the bottom level to the level's own value.
module pgstk_entry
    import pgstk_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic              sw_wr,
    input  logic [PAGE_W-1:0] sw_wdata,
    input  logic [PAGE_W-1:0] above_q,
    input  logic [PAGE_W-1:0] below_q,
    output logic [PAGE_W-1:0] q
);
    // Level register with interrupt events ahead of software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_PUSH: q <= above_q;
                OP_POP:  q <= below_q;
                default: if (sw_wr) q <= sw_wdata;
            endcase
        end
    end
endmodule

// File: rtl/pgstk_rdmux.sv
// Module: pgstk_rdmux
// Software read selector over all levels; unused select codes read zero.
// Assumes: level 0 is the top.
module pgstk_rdmux #(
    parameter int PAGE_W = 8,
    parameter int DEPTH  = 3,
    parameter int SEL_W  = 2
) (
    input  logic [DEPTH-1:0][PAGE_W-1:0] stk,
    input  logic [SEL_W-1:0]             sel,
    output logic [PAGE_W-1:0]            rdata
);
    // Select the addressed level.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i)) rdata = stk[i];
        end
    end
endmodule

// File: rtl/page_stack.sv
// Module: page_stack
// Hardware stack of register page selectors, pushed on interrupt entry and
// popped on interrupt return; every level is software readable and writable.
// Assumes: strobes are single-cycle; level 0 drives the active page.
module page_stack
    import pgstk_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int DEPTH  = 3,
    localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stk_en,
    input  logic              irq_enter,
    input  logic [PAGE_W-1:0] irq_page,
    input  logic              irq_return,
    input  logic [DEPTH-1:0]  sw_wr_en,
    input  logic [PAGE_W-1:0] sw_wdata,
    input  logic [SEL_W-1:0]  sw_rd_sel,
    output logic [PAGE_W-1:0] sw_rdata,
    output logic [PAGE_W-1:0] active_page
);
    stk_op_e                     op;
    logic [DEPTH-1:0][PAGE_W-1:0] stk_q;

    pgstk_ctrl ctrl_i (
        .stk_en     (stk_en),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .op         (op)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        logic [PAGE_W-1:0] above;
        logic [PAGE_W-1:0] below;
        if (g == 0) begin : g_top
            assign above = irq_page;
        end else begin : g_mid
            assign above = stk_q[g-1];
        end
        if (g == DEPTH-1) begin : g_bot
            assign below = stk_q[g];
        end else begin : g_up
            assign below = stk_q[g+1];
        end
        pgstk_entry #(.PAGE_W(PAGE_W)) entry_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .sw_wr    (sw_wr_en[g]),
            .sw_wdata (sw_wdata),
            .above_q  (above),
            .below_q  (below),
            .q        (stk_q[g])
        );
    end

    pgstk_rdmux #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) rd_i (
        .stk   (stk_q),
        .sel   (sw_rd_sel),
        .rdata (sw_rdata)
    );

    // The top level is the page seen by the register decoder.
    assign active_page = stk_q[0];
endmodule

// File: rtl/page_stack_chk.sv
// Module: page_stack_chk
// Temporal checks on the page stack, attached by bind.
// Assumes: DEPTH >= 2.
module page_stack_chk #(
    parameter int PAGE_W = 8,
    parameter int DEPTH  = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          stk_en,
    input logic                          irq_enter,
    input logic                          irq_return,
    input logic [PAGE_W-1:0]             irq_page,
    input logic [DEPTH-1:0]              sw_wr_en,
    input logic [PAGE_W-1:0]             sw_wdata,
    input logic [DEPTH-1:0][PAGE_W-1:0]  stk_q,
    input logic [PAGE_W-1:0]             active_page
);
    a_r3_push: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en && irq_enter) |=>
            (active_page == $past(irq_page)) && (stk_q[1] == $past(stk_q[0])));

    a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en && irq_return && !irq_enter) |=>
            (active_page == $past(stk_q[1])) && (stk_q[DEPTH-1] == $past(stk_q[DEPTH-1])));

    a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk_en && (sw_wr_en == '0)) |=> $stable(stk_q));

    a_r6_sw_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stk_en && (irq_enter || irq_return)) && sw_wr_en[0]) |=>
            (active_page == $past(sw_wdata)));

    a_r7_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en && irq_enter && sw_wr_en[DEPTH-1]) |=>
            (stk_q[DEPTH-1] == $past(stk_q[DEPTH-2])));
endmodule

bind page_stack page_stack_chk #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stk_en      (stk_en),
    .irq_enter   (irq_enter),
    .irq_return  (irq_return),
    .irq_page    (irq_page),
    .sw_wr_en    (sw_wr_en),
    .sw_wdata    (sw_wdata),
    .stk_q       (stk_q),
    .active_page (active_page)
);

// File: tb/page_stack_tb_top.sv
`timescale 1ns/100ps
module page_stack_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stk_en = 1'b1;
    logic       irq_enter = 1'b0;
    logic [7:0] irq_page = '0;
    logic       irq_return = 1'b0;
    logic [2:0] sw_wr_en = '0;
    logic [7:0] sw_wdata = '0;
    logic [1:0] sw_rd_sel = '0;
    logic [7:0] sw_rdata;
    logic [7:0] active_page;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q [3];

    always #2.5 clk = ~clk;

    page_stack dut_i (
        .clk(clk), .rst_n(rst_n), .stk_en(stk_en),
        .irq_enter(irq_enter), .irq_page(irq_page), .irq_return(irq_return),
        .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
        .sw_rd_sel(sw_rd_sel), .sw_rdata(sw_rdata), .active_page(active_page)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Read every level through the read port and compare with the model.
    task automatic check_all(input string req);
        for (int i = 0; i < 3; i++) begin
            sw_rd_sel = 2'(i);
            #0.2;
            chk(req, $sformatf("level %0d", i), sw_rdata, exp_q[i]);
        end
        chk(req, "active_page", active_page, exp_q[0]);
    endtask

    // One clock with the given stimulus; model updated from the requirements.
    task automatic step(input logic en, input logic ent, input logic [7:0] pg,
                        input logic ret, input logic [2:0] we, input logic [7:0] wd);
        @(negedge clk);
        stk_en = en; irq_enter = ent; irq_page = pg; irq_return = ret;
        sw_wr_en = we; sw_wdata = wd;
        @(posedge clk);
        if (en && ent) begin             // R3, R8
            exp_q[2] = exp_q[1]; exp_q[1] = exp_q[0]; exp_q[0] = pg;
        end else if (en && ret) begin    // R4
            exp_q[0] = exp_q[1]; exp_q[1] = exp_q[2];
        end else begin                   // R5, R6, R7
            for (int i = 0; i < 3; i++) if (we[i]) exp_q[i] = wd;
        end
        #1;
        irq_enter = 1'b0; irq_return = 1'b0; sw_wr_en = '0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) exp_q[i] = 8'h00;
        check_all("R1");
    endtask

    task automatic t_sw_write;
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'b001, 8'h0F);
        check_all("R2/R6 top write");
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'b010, 8'h22);
        check_all("R6 mid write");
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'b100, 8'h33);
        check_all("R6 bottom write");
        sw_rd_sel = 2'd3;
        #0.2;
        chk("R9", "select 3", sw_rdata, 8'h00);
    endtask

    task automatic t_nested;
        step(1'b1, 1'b1, 8'h00, 1'b0, 3'b000, 8'h00);
        check_all("R3 first entry");
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'b001, 8'h05);
        check_all("R2 write in handler");
        step(1'b1, 1'b1, 8'h10, 1'b0, 3'b000, 8'h00);
        check_all("R3 nested entry");
        step(1'b1, 1'b0, 8'h00, 1'b1, 3'b000, 8'h00);
        check_all("R4 first return");
        step(1'b1, 1'b0, 8'h00, 1'b1, 3'b000, 8'h00);
        check_all("R4 second return");
        chk("R10", "restored page", active_page, 8'h0F);
    endtask

    task automatic t_disabled;
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'b110, 8'h44);
        step(1'b0, 1'b1, 8'h77, 1'b0, 3'b000, 8'h00);
        check_all("R5 entry ignored");
        step(1'b0, 1'b0, 8'h00, 1'b1, 3'b000, 8'h00);
        check_all("R5 return ignored");
        step(1'b0, 1'b1, 8'h77, 1'b1, 3'b001, 8'h5A);
        check_all("R7 write while disabled");
    endtask

    task automatic t_conflict;
        step(1'b1, 1'b0, 8'h00, 1'b0, 3'b110, 8'h66);
        step(1'b1, 1'b1, 8'h21, 1'b0, 3'b111, 8'hAA);
        check_all("R7 entry beats write");
        step(1'b1, 1'b0, 8'h00, 1'b1, 3'b111, 8'hBB);
        check_all("R7 return beats write");
        step(1'b1, 1'b1, 8'h3C, 1'b1, 3'b000, 8'h00);
        check_all("R8 entry and return together");
        chk("R8", "active after both", active_page, 8'h3C);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw_write();
        t_nested();
        t_disabled();
        t_conflict();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule